// File: doc/BRIEF.md
# Burst-of-Two DDR SRAM Data Path

This block is the data path of a synchronous SRAM with one shared data bus that moves two beats per clock. The beats sit in a rising-edge slot and a falling-edge slot. The storage array is twice as wide as one beat, so one burst of two beats fills exactly one array word. A write command names a word and a starting half. Its two data beats arrive in the clock after the command, each with its own beat-valid flag and one enable per 9-bit byte lane. The block gathers both beats into one wide word and commits that word to the array one clock later.

A read command fetches one wide word and returns both halves two clocks after the command. The half selected by the low address bit comes out in the rising slot. A read can reach the array while an earlier write is still waiting to commit. In that case the waiting bytes are merged over the array contents lane by lane, so every read returns the most recent data. Reads and writes may be issued in any mix on every clock, and the block never stalls.

Top module: `bdp_ddr_b2_path`

## Requirements
- R1: While reset is active, and after it until the first read returns, rd_vld is 0 and both read data outputs are 0.
- R2: For a write with cmd_addr[0]=0, the rising-slot beat goes to the low half (bits DW-1:0) of word cmd_addr[AW-1:1], and the falling-slot beat goes to the high half.
- R3: For a write with cmd_addr[0]=1, the rising-slot beat goes to the high half and the falling-slot beat goes to the low half.
- R4: A read with cmd_addr[0]=0 returns the low half on rd_rise_data and the high half on rd_fall_data. With cmd_addr[0]=1 the two halves are swapped.
- R5: A read command (cmd_valid=1, cmd_write=0) accepted in cycle c raises rd_vld in cycle c+2 and in no other cycle because of that command. Write commands never raise rd_vld.
- R6: Write beats are taken only in the cycle right after a write command, and the array changes only in the cycle after that. Beat slots in any other cycle are ignored.
- R7: Byte-enable bit i of a beat covers data bits 9i+8..9i of that beat. A lane whose enable is 0 keeps its old array contents.
- R8: A beat whose valid flag is 0 writes nothing, whatever its byte enables are.
- R9: A read of a word issued in the cycle right after a write to that word returns the new bytes, merged lane by lane with the older contents.
- R10: Any sequence of read and write commands, one per cycle and alternating if wanted, runs with no stall and gives correct data on every read.
- R11: While rd_vld is 0, rd_rise_data and rd_fall_data keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Word index in bits AW-1:1, starting half in bit 0 |
| wr_rise_vld | input | 1 | Rising-slot write beat valid |
| wr_rise_data | input | DW | Rising-slot write beat |
| wr_rise_be | input | DW/9 | Rising-slot byte-lane enables |
| wr_fall_vld | input | 1 | Falling-slot write beat valid |
| wr_fall_data | input | DW | Falling-slot write beat |
| wr_fall_be | input | DW/9 | Falling-slot byte-lane enables |
| rd_vld | output | 1 | Read beats valid this cycle |
| rd_rise_data | output | DW | First read beat |
| rd_fall_data | output | DW | Second read beat |

## Verification
The hardest case to reach is a read whose array lookup falls in the one cycle when an earlier write is assembled but not yet committed. It is harder still when that write enabled only some lanes, or masked a whole beat, so that the result must mix new and old bytes. The stimulus reaches this case by issuing a partial write and then a read of the same word on the very next clock. It also runs long runs of alternating writes and reads over a few words, with both starting halves, and checks every cycle against a behavioural memory model.

// File: rtl/bdp_pkg.sv
`timescale 1ns/1ps
package bdp_pkg;

  // Which half of the wide word travels in the rising slot.
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/bdp_wr_demux.sv
`timescale 1ns/1ps
module bdp_wr_demux
  import bdp_pkg::*;
#(
  parameter int DW    = 36,
  parameter int LW    = 9,
  parameter int IDXW  = 4,
  localparam int NL   = DW / LW,
  localparam int WW   = 2 * DW,
  localparam int WL   = 2 * NL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_go,
  input  logic [IDXW-1:0] cmd_idx,
  input  logic            cmd_a0,
  input  logic            rise_vld,
  input  logic [DW-1:0]   rise_data,
  input  logic [NL-1:0]   rise_be,
  input  logic            fall_vld,
  input  logic [DW-1:0]   fall_data,
  input  logic [NL-1:0]   fall_be,
  output logic            pend_vld,
  output logic [IDXW-1:0] pend_idx,
  output logic [WW-1:0]   pend_data,
  output logic [WL-1:0]   pend_be
);

  // address stage: write accepted, beats due this cycle
  logic            wa_vld;
  logic [IDXW-1:0] wa_idx;
  half_e           wa_first;

  logic [NL-1:0]   rise_lanes;
  logic [NL-1:0]   fall_lanes;
  logic [WW-1:0]   word_nx;
  logic [WL-1:0]   be_nx;

  always_comb begin
    rise_lanes = rise_vld ? rise_be : '0;
    fall_lanes = fall_vld ? fall_be : '0;
    if (wa_first == HALF_HI) begin
      word_nx = {rise_data, fall_data};
      be_nx   = {rise_lanes, fall_lanes};
    end else begin
      word_nx = {fall_data, rise_data};
      be_nx   = {fall_lanes, rise_lanes};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_vld   <= 1'b0;
      wa_idx   <= '0;
      wa_first <= HALF_LO;
    end else begin
      wa_vld <= wr_go;
      if (wr_go) begin
        wa_idx   <= cmd_idx;
        wa_first <= half_e'(cmd_a0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
      pend_be   <= '0;
    end else begin
      pend_vld <= wa_vld;
      if (wa_vld) begin
        pend_idx  <= wa_idx;
        pend_data <= word_nx;
        pend_be   <= be_nx;
      end
    end
  end

endmodule

// File: rtl/bdp_array.sv
`timescale 1ns/1ps
module bdp_array #(
  parameter int LW    = 9,
  parameter int WL    = 8,
  parameter int DEPTH = 16,
  localparam int WW   = WL * LW,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [WW-1:0]   wdata,
  input  logic [WL-1:0]   wbe,
  input  logic [IDXW-1:0] ridx,
  output logic [WW-1:0]   rdata
);

  // one storage column per byte lane, each with its own write enable
  for (genvar l = 0; l < WL; l++) begin : g_lane
    logic [LW-1:0] col [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[l]) begin
        col[widx] <= wdata[l*LW +: LW];
      end
    end

    assign rdata[l*LW +: LW] = col[ridx];
  end

endmodule

// File: rtl/bdp_rd_mux.sv
`timescale 1ns/1ps
module bdp_rd_mux
  import bdp_pkg::*;
#(
  parameter int DW    = 36,
  parameter int LW    = 9,
  parameter int IDXW  = 4,
  localparam int NL   = DW / LW,
  localparam int WW   = 2 * DW,
  localparam int WL   = 2 * NL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_go,
  input  logic [IDXW-1:0] cmd_idx,
  input  logic            cmd_a0,
  input  logic [WW-1:0]   arr_rdata,
  output logic [IDXW-1:0] arr_ridx,
  input  logic            pend_vld,
  input  logic [IDXW-1:0] pend_idx,
  input  logic [WW-1:0]   pend_data,
  input  logic [WL-1:0]   pend_be,
  output logic            rd_vld,
  output logic [DW-1:0]   rd_rise,
  output logic [DW-1:0]   rd_fall
);

  logic            r1_vld;
  logic [IDXW-1:0] r1_idx;
  half_e           r1_first;

  logic            fwd_hit;
  logic [WW-1:0]   merged;
  logic [DW-1:0]   rise_nx;
  logic [DW-1:0]   fall_nx;

  assign arr_ridx = r1_idx;
  assign fwd_hit  = pend_vld && (pend_idx == r1_idx);

  // lane-wise bypass of the write still waiting to commit
  for (genvar l = 0; l < WL; l++) begin : g_fwd
    assign merged[l*LW +: LW] = (fwd_hit && pend_be[l]) ? pend_data[l*LW +: LW]
                                                        : arr_rdata[l*LW +: LW];
  end

  always_comb begin
    if (r1_first == HALF_HI) begin
      rise_nx = merged[WW-1:DW];
      fall_nx = merged[DW-1:0];
    end else begin
      rise_nx = merged[DW-1:0];
      fall_nx = merged[WW-1:DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_vld   <= 1'b0;
      r1_idx   <= '0;
      r1_first <= HALF_LO;
    end else begin
      r1_vld <= rd_go;
      if (rd_go) begin
        r1_idx   <= cmd_idx;
        r1_first <= half_e'(cmd_a0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_rise <= '0;
      rd_fall <= '0;
    end else begin
      rd_vld <= r1_vld;
      if (r1_vld) begin
        rd_rise <= rise_nx;
        rd_fall <= fall_nx;
      end
    end
  end

endmodule

// File: rtl/bdp_ddr_b2_path.sv
`timescale 1ns/1ps
module bdp_ddr_b2_path
  import bdp_pkg::*;
#(
  parameter int DW    = 36,
  parameter int LW    = 9,
  parameter int DEPTH = 16,
  localparam int NL   = DW / LW,
  localparam int WW   = 2 * DW,
  localparam int WL   = 2 * NL,
  localparam int IDXW = $clog2(DEPTH),
  localparam int AW   = IDXW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic          wr_rise_vld,
  input  logic [DW-1:0] wr_rise_data,
  input  logic [NL-1:0] wr_rise_be,
  input  logic          wr_fall_vld,
  input  logic [DW-1:0] wr_fall_data,
  input  logic [NL-1:0] wr_fall_be,
  output logic          rd_vld,
  output logic [DW-1:0] rd_rise_data,
  output logic [DW-1:0] rd_fall_data
);

  op_e             op;
  logic            wr_go;
  logic            rd_go;
  logic [IDXW-1:0] cmd_idx;
  logic            cmd_a0;

  logic            pend_vld;
  logic [IDXW-1:0] pend_idx;
  logic [WW-1:0]   pend_data;
  logic [WL-1:0]   pend_be;

  logic [IDXW-1:0] arr_ridx;
  logic [WW-1:0]   arr_rdata;

  always_comb begin
    if (!cmd_valid)     op = OP_NONE;
    else if (cmd_write) op = OP_WRITE;
    else                op = OP_READ;
  end

  assign wr_go   = (op == OP_WRITE);
  assign rd_go   = (op == OP_READ);
  assign cmd_idx = cmd_addr[AW-1:1];
  assign cmd_a0  = cmd_addr[0];

  bdp_wr_demux #(.DW(DW), .LW(LW), .IDXW(IDXW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go     (wr_go),
    .cmd_idx   (cmd_idx),
    .cmd_a0    (cmd_a0),
    .rise_vld  (wr_rise_vld),
    .rise_data (wr_rise_data),
    .rise_be   (wr_rise_be),
    .fall_vld  (wr_fall_vld),
    .fall_data (wr_fall_data),
    .fall_be   (wr_fall_be),
    .pend_vld  (pend_vld),
    .pend_idx  (pend_idx),
    .pend_data (pend_data),
    .pend_be   (pend_be)
  );

  bdp_array #(.LW(LW), .WL(WL), .DEPTH(DEPTH)) u_arr (
    .clk   (clk),
    .we    (pend_vld),
    .widx  (pend_idx),
    .wdata (pend_data),
    .wbe   (pend_be),
    .ridx  (arr_ridx),
    .rdata (arr_rdata)
  );

  bdp_rd_mux #(.DW(DW), .LW(LW), .IDXW(IDXW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_go     (rd_go),
    .cmd_idx   (cmd_idx),
    .cmd_a0    (cmd_a0),
    .arr_rdata (arr_rdata),
    .arr_ridx  (arr_ridx),
    .pend_vld  (pend_vld),
    .pend_idx  (pend_idx),
    .pend_data (pend_data),
    .pend_be   (pend_be),
    .rd_vld    (rd_vld),
    .rd_rise   (rd_rise_data),
    .rd_fall   (rd_fall_data)
  );

endmodule

// File: rtl/bdp_chk.sv
`timescale 1ns/1ps
module bdp_chk #(
  parameter int DW = 36,
  parameter int WL = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_write,
  input logic          rd_vld,
  input logic [DW-1:0] rd_rise_data,
  input logic [DW-1:0] rd_fall_data,
  input logic          arr_we,
  input logic [WL-1:0] arr_wbe
);

  logic rd_seen1, rd_seen2;
  logic wr_seen1, wr_seen2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_seen1 <= 1'b0;
      rd_seen2 <= 1'b0;
      wr_seen1 <= 1'b0;
      wr_seen2 <= 1'b0;
    end else begin
      rd_seen1 <= cmd_valid && !cmd_write;
      rd_seen2 <= rd_seen1;
      wr_seen1 <= cmd_valid && cmd_write;
      wr_seen2 <= wr_seen1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rd_vld);

  // R5
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld == rd_seen2);

  // R6
  commit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && (arr_wbe != '0)) |-> wr_seen2);

  // R11
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld |-> ($stable(rd_rise_data) && $stable(rd_fall_data)));

endmodule

bind bdp_ddr_b2_path bdp_chk #(.DW(DW), .WL(WL)) u_bdp_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_write    (cmd_write),
  .rd_vld       (rd_vld),
  .rd_rise_data (rd_rise_data),
  .rd_fall_data (rd_fall_data),
  .arr_we       (pend_vld),
  .arr_wbe      (pend_be)
);

// File: tb/tb_bdp_ddr_b2_path.sv
`timescale 1ns/1ps
module tb_bdp_ddr_b2_path;

  localparam int DW    = 36;
  localparam int LW    = 9;
  localparam int DEPTH = 16;
  localparam int NL    = DW / LW;
  localparam int IDXW  = $clog2(DEPTH);
  localparam int AW    = IDXW + 1;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic          wr_rise_vld, wr_fall_vld;
  logic [DW-1:0] wr_rise_data, wr_fall_data;
  logic [NL-1:0] wr_rise_be, wr_fall_be;
  logic          rd_vld;
  logic [DW-1:0] rd_rise_data, rd_fall_data;

  bdp_ddr_b2_path #(.DW(DW), .LW(LW), .DEPTH(DEPTH)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_write    (cmd_write),
    .cmd_addr     (cmd_addr),
    .wr_rise_vld  (wr_rise_vld),
    .wr_rise_data (wr_rise_data),
    .wr_rise_be   (wr_rise_be),
    .wr_fall_vld  (wr_fall_vld),
    .wr_fall_data (wr_fall_data),
    .wr_fall_be   (wr_fall_be),
    .rd_vld       (rd_vld),
    .rd_rise_data (rd_rise_data),
    .rd_fall_data (rd_fall_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_cmp  = 0;
  int n_bad  = 0;
  int nstep  = 0;
  bit done   = 0;

  // behavioural memory: two halves per word
  logic [DW-1:0] mlo [DEPTH];
  logic [DW-1:0] mhi [DEPTH];

  typedef struct {
    int            due;
    logic [DW-1:0] r;
    logic [DW-1:0] f;
    string         tag;
  } exp_t;
  exp_t q[$];
  logic [DW-1:0] last_r, last_f;

  // beats scheduled for the cycle after a write command
  bit            sch_vld;
  logic [AW-1:0] sch_a;
  logic [DW-1:0] sch_rd, sch_fd;
  logic [NL-1:0] sch_rbe, sch_fbe;
  logic          sch_rv, sch_fv;
  logic [DW-1:0] nx_rd, nx_fd;
  logic [NL-1:0] nx_rbe, nx_fbe;
  logic          nx_rv, nx_fv;

  function automatic logic [DW-1:0] pat(int s);
    logic [31:0] m;
    m = 32'(s) * 32'h9E37_79B1;
    return {4'(s), m};
  endfunction

  task automatic model_apply();
    int idx;
    idx = int'(sch_a[AW-1:1]);
    for (int i = 0; i < NL; i++) begin
      if (sch_rv && sch_rbe[i]) begin
        if (sch_a[0]) mhi[idx][i*LW +: LW] = sch_rd[i*LW +: LW];
        else          mlo[idx][i*LW +: LW] = sch_rd[i*LW +: LW];
      end
      if (sch_fv && sch_fbe[i]) begin
        if (sch_a[0]) mlo[idx][i*LW +: LW] = sch_fd[i*LW +: LW];
        else          mhi[idx][i*LW +: LW] = sch_fd[i*LW +: LW];
      end
    end
  endtask

  task automatic compare();
    exp_t e;
    n_cmp++;
    if (q.size() > 0 && q[0].due == nstep) begin
      e = q.pop_front();
      if (rd_vld !== 1'b1 || rd_rise_data !== e.r || rd_fall_data !== e.f) begin
        n_bad++;
        $display("FAIL %s step %0d: vld=%b rise=%h fall=%h expected vld=1 rise=%h fall=%h",
                 e.tag, nstep, rd_vld, rd_rise_data, rd_fall_data, e.r, e.f);
      end
      last_r = e.r;
      last_f = e.f;
    end else begin
      if (rd_vld !== 1'b0 || rd_rise_data !== last_r || rd_fall_data !== last_f) begin
        n_bad++;
        $display("FAIL R5 R11 step %0d: vld=%b rise=%h fall=%h expected vld=0 rise=%h fall=%h",
                 nstep, rd_vld, rd_rise_data, rd_fall_data, last_r, last_f);
      end
    end
  endtask

  // one clock: check outputs, drive beats and command, update model
  task automatic step(input logic cv, input logic cw, input logic [AW-1:0] a, input string tag);
    exp_t e;
    compare();
    if (sch_vld) begin
      wr_rise_vld  = sch_rv;  wr_rise_data = sch_rd;  wr_rise_be = sch_rbe;
      wr_fall_vld  = sch_fv;  wr_fall_data = sch_fd;  wr_fall_be = sch_fbe;
      model_apply();
    end else begin
      // R6: stray beats with no write in the previous cycle
      wr_rise_vld  = 1'b1;  wr_rise_data = pat(5000 + nstep);  wr_rise_be = '1;
      wr_fall_vld  = 1'b1;  wr_fall_data = pat(7000 + nstep);  wr_fall_be = '1;
    end
    cmd_valid = cv;
    cmd_write = cw;
    cmd_addr  = a;
    if (cv && cw) begin
      sch_vld = 1;  sch_a = a;
      sch_rd = nx_rd;  sch_rbe = nx_rbe;  sch_rv = nx_rv;
      sch_fd = nx_fd;  sch_fbe = nx_fbe;  sch_fv = nx_fv;
    end else begin
      sch_vld = 0;
    end
    if (cv && !cw) begin
      e.due = nstep + 2;
      e.tag = tag;
      if (a[0]) begin e.r = mhi[int'(a[AW-1:1])]; e.f = mlo[int'(a[AW-1:1])]; end
      else      begin e.r = mlo[int'(a[AW-1:1])]; e.f = mhi[int'(a[AW-1:1])]; end
      q.push_back(e);
    end
    nstep++;
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input bit a0,
                    input logic [DW-1:0] rd, input logic [NL-1:0] rbe, input logic rv,
                    input logic [DW-1:0] fd, input logic [NL-1:0] fbe, input logic fv);
    nx_rd = rd;  nx_rbe = rbe;  nx_rv = rv;
    nx_fd = fd;  nx_fbe = fbe;  nx_fv = fv;
    step(1'b1, 1'b1, {IDXW'(idx), a0}, "");
  endtask

  task automatic rd(input int idx, input bit a0, input string tag);
    step(1'b1, 1'b0, {IDXW'(idx), a0}, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, "");
  endtask

  // watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mlo[i] = '0; mhi[i] = '0; end
    last_r = '0; last_f = '0; sch_vld = 0;
    rst_n = 1'b0;
    cmd_valid = 0; cmd_write = 0; cmd_addr = '0;
    wr_rise_vld = 0; wr_rise_data = '0; wr_rise_be = '0;
    wr_fall_vld = 0; wr_fall_data = '0; wr_fall_be = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    n_cmp++;
    if (rd_vld !== 1'b0 || rd_rise_data !== '0 || rd_fall_data !== '0) begin
      n_bad++;
      $display("FAIL R1 in reset: vld=%b rise=%h fall=%h expected vld=0 rise=0 fall=0",
               rd_vld, rd_rise_data, rd_fall_data);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // fill every word, starting half alternating (R2, R3)
    for (int i = 0; i < DEPTH; i++)
      wr(i, i[0], pat(i), '1, 1'b1, pat(100 + i), '1, 1'b1);
    idle(2);
    // back-to-back reads in both orders (R4, R5)
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, 1'b0, "R2 R3 R4");
      rd(i, 1'b1, "R4 R5");
    end
    idle(2);

    // four A0/command combinations
    wr(5, 1'b0, pat(200), '1, 1'b1, pat(201), '1, 1'b1);
    idle(1);
    rd(5, 1'b0, "R2 R4 a0w0 a0r0");
    rd(5, 1'b1, "R2 R4 a0w0 a0r1");
    wr(6, 1'b1, pat(210), '1, 1'b1, pat(211), '1, 1'b1);
    idle(1);
    rd(6, 1'b0, "R3 R4 a0w1 a0r0");
    rd(6, 1'b1, "R3 R4 a0w1 a0r1");
    idle(2);

    // R7: byte-lane enables
    wr(7, 1'b0, pat(300), 4'b0101, 1'b1, pat(301), 4'b1010, 1'b1);
    idle(2);
    rd(7, 1'b0, "R7");
    wr(4, 1'b1, pat(310), 4'b1000, 1'b1, pat(311), 4'b0001, 1'b1);
    idle(2);
    rd(4, 1'b1, "R7");

    // R8: masked beats
    wr(8, 1'b1, pat(400), '1, 1'b0, pat(401), '1, 1'b1);
    idle(2);
    rd(8, 1'b0, "R8");
    wr(9, 1'b0, pat(410), '1, 1'b1, pat(411), '1, 1'b0);
    idle(2);
    rd(9, 1'b1, "R8");

    // R9: read right after a write to the same word
    wr(10, 1'b0, pat(500), 4'b0011, 1'b1, pat(501), 4'b1100, 1'b1);
    rd(10, 1'b0, "R9 partial");
    rd(10, 1'b1, "R9 after commit");
    wr(11, 1'b1, pat(510), '1, 1'b1, pat(511), '1, 1'b1);
    rd(11, 1'b1, "R9 full");
    wr(12, 1'b1, pat(520), 4'b0110, 1'b0, pat(521), 4'b1001, 1'b1);
    rd(12, 1'b0, "R9 R8 masked");
    // two writes to one word, then read
    wr(2, 1'b0, pat(530), 4'b0001, 1'b1, pat(531), 4'b0000, 1'b1);
    wr(2, 1'b1, pat(540), 4'b0000, 1'b1, pat(541), 4'b0010, 1'b1);
    rd(2, 1'b0, "R9 R10 double write");
    idle(2);

    // R10: alternating writes and reads, no stall
    for (int k = 0; k < 16; k++) begin
      int wi;
      wi = (k * 5) % 4 + 12;
      wr(wi, k[0], pat(600 + k), 4'(k + 3), 1'b1, pat(700 + k), 4'(k * 7 + 1), k[1] | k[0]);
      if (k[1]) rd(wi, k[2], "R10 R9 same word");
      else      rd((k * 3) % DEPTH, k[3], "R10 other word");
    end
    idle(2);

    // R6: stray beats in idle cycles changed nothing
    idle(3);
    rd(0, 1'b0, "R6");
    rd(1, 1'b1, "R6");
    rd(13, 1'b0, "R6");
    idle(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule